// File: doc/BRIEF.md
# Playback Format Decoder and DMA Request Controller

This block turns a one-byte playback control word into a registered playback configuration: which crystal feeds the sample clock, the rate index within that crystal, mono or stereo, the sample encoding (8-bit unsigned, linear 16-bit in either byte order, or one of two companded forms that expand to 16-bit), and the per-frame shift used to turn a byte count into a frame count. The same setup step drives the hold line of a DMA request channel and an output-active flag for the playback path.

The control word is sampled only when the one-cycle `reconfig` strobe is high. In the same cycle, an external validity mask is consulted for the selected crystal/rate pair. A setting that is reserved, unsupported or has an invalid rate aborts the setup. The previous configuration is kept, an error flag is set and any running DMA request is dropped. A good setting with playback enabled starts the DMA request if it is not already running and pulses a clear for the transfer counter. A good setting with playback disabled stops it.

Top module: `pfmt_dreq_ctrl`

## Requirements
- R1: After a good reconfigure, `xtal_sel` equals control bit 0 and `rate_idx` equals control bits 3:1.
- R2: After a good reconfigure, `stereo` equals control bit 4 (1 = two channels, 0 = one channel).
- R3: The encoding code is taken from control bits 7:5 when `ext_mode` is 1, and from bits 6:5 only (bit 7 read as 0) when `ext_mode` is 0.
- R4: Encoding codes map as follows. Code 0 gives `wide16`=0, `lut_sel`=0. Code 1 gives `wide16`=1, `lut_sel`=1 (mu-law). Code 3 gives `wide16`=1, `lut_sel`=2 (A-law). Code 2 gives `wide16`=1, `lut_sel`=0, `big_endian`=0. Code 6 gives `wide16`=1, `lut_sel`=0, `big_endian`=1. `big_endian` is 0 for every code other than 6.
- R5: Codes 4, 5 and 7 set `cfg_err`=1 and leave every decoded output unchanged.
- R6: `frame_shift` is 2 for linear 16-bit stereo and 1 for linear 16-bit mono. For 8-bit or companded encodings it is 1 for stereo and 0 for mono.
- R7: When bit {crystal, rate index} of `rate_ok_mask` is 0, with the crystal bit as the most significant bit of the index, the reconfigure is an error with the same effect as R5. A good reconfigure clears `cfg_err`.
- R8: A good reconfigure with `play_en`=1 sets `dreq_hold` and `out_active` to 1. `xfer_clr` pulses for exactly one cycle only if they were 0 before.
- R9: A reconfigure with `play_en`=0, or any erroneous reconfigure, sets `dreq_hold`, `out_active` and `xfer_clr` to 0.
- R10: All outputs change only on the clock edge that samples `reconfig`=1. Without the strobe, they hold their values and `xfer_clr` is 0.
- R11: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_byte | input | 8 | Playback format/rate control word |
| ext_mode | input | 1 | Extended mode: 3-bit encoding field |
| play_en | input | 1 | Playback enable |
| reconfig | input | 1 | One-cycle setup strobe |
| rate_ok_mask | input | 16 | Valid flag per {crystal, rate index} |
| xtal_sel | output | 1 | Selected crystal |
| rate_idx | output | 3 | Rate index within crystal |
| stereo | output | 1 | Two channels when 1 |
| wide16 | output | 1 | Samples delivered as 16-bit |
| big_endian | output | 1 | 16-bit samples most significant byte first |
| frame_shift | output | 2 | Byte-to-frame shift amount |
| lut_sel | output | 2 | Expansion table: 0 none, 1 mu-law, 2 A-law |
| cfg_err | output | 1 | Last reconfigure was rejected |
| dreq_hold | output | 1 | DMA request held |
| out_active | output | 1 | Playback output active |
| xfer_clr | output | 1 | One-cycle transfer counter clear |

## Verification
The hardest state to reach is a rejected setup that arrives while DMA is already running. The decoded fields must then stay frozen while the request drops. The bench first makes a good, enabled setup with distinctive field values. It then strobes a reserved code, and separately a valid code paired with a cleared rate-mask bit, and compares every field against the values held from before. A second subtle point is that the transfer clear must not pulse again when a setup arrives while already running. The bench covers this by issuing two enabled setups back to back.

// File: rtl/pfmt_pkg.sv
package pfmt_pkg;
  localparam int RATE_W = 3;

  typedef enum logic [1:0] {
    LUT_NONE  = 2'd0,
    LUT_MULAW = 2'd1,
    LUT_ALAW  = 2'd2
  } lut_e;

  typedef struct packed {
    logic              xtal;
    logic [RATE_W-1:0] rate;
    logic              stereo;
    logic              w16;
    logic              big_end;
    logic [1:0]        shift;
    lut_e              lut;
  } pcfg_t;
endpackage

// File: rtl/pfmt_decode.sv
module pfmt_decode
  import pfmt_pkg::*;
#(
  parameter int ENC_W = 3
) (
  input  logic [RATE_W+ENC_W+1:0] fmt,
  input  logic                    ext_mode,
  output pcfg_t                   cfg,
  output logic                    enc_bad
);
  localparam int XTAL_BIT   = 0;
  localparam int RATE_LSB   = XTAL_BIT + 1;
  localparam int STEREO_BIT = RATE_LSB + RATE_W;
  localparam int ENC_LSB    = STEREO_BIT + 1;

  logic [ENC_W-1:0] enc_mask;
  logic [ENC_W-1:0] code;
  logic             lin16;

  always_comb begin
    enc_mask = ext_mode ? {ENC_W{1'b1}} : {1'b0, {(ENC_W-1){1'b1}}};
    code     = fmt[ENC_LSB +: ENC_W] & enc_mask;
  end

  always_comb begin
    cfg.xtal    = fmt[XTAL_BIT];
    cfg.rate    = fmt[RATE_LSB +: RATE_W];
    cfg.stereo  = fmt[STEREO_BIT];
    cfg.w16     = 1'b1;
    cfg.big_end = 1'b0;
    cfg.lut     = LUT_NONE;
    enc_bad     = 1'b0;
    case (code)
      3'd0: cfg.w16 = 1'b0;
      3'd1: cfg.lut = LUT_MULAW;
      3'd2: ;
      3'd3: cfg.lut = LUT_ALAW;
      3'd6: cfg.big_end = 1'b1;
      default: enc_bad = 1'b1;
    endcase
    lin16 = cfg.w16 && (cfg.lut == LUT_NONE);
    if (lin16) cfg.shift = cfg.stereo ? 2'd2 : 2'd1;
    else       cfg.shift = cfg.stereo ? 2'd1 : 2'd0;
  end
endmodule

// File: rtl/pfmt_rate_chk.sv
module pfmt_rate_chk #(
  parameter int RATE_W = 3,
  localparam int IDX_W = RATE_W + 1,
  localparam int MASK_N = 1 << IDX_W
) (
  input  logic              xtal,
  input  logic [RATE_W-1:0] rate,
  input  logic [MASK_N-1:0] mask,
  output logic              rate_ok
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx     = {xtal, rate};
    rate_ok = mask[idx];
  end
endmodule

// File: rtl/pfmt_dreq_fsm.sv
module pfmt_dreq_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic play_en,
  input  logic setup_err,
  output logic dreq_hold,
  output logic out_active,
  output logic xfer_clr
);
  logic run_q, run_d;
  logic act_q, act_d;
  logic clr_q, clr_d;
  logic past_ok_q;

  always_comb begin
    run_d = run_q;
    act_d = act_q;
    clr_d = 1'b0;
    if (strobe) begin
      if (setup_err || !play_en) begin
        run_d = 1'b0;
        act_d = 1'b0;
      end else begin
        clr_d = !run_q;
        run_d = 1'b1;
        act_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      act_q     <= 1'b0;
      clr_q     <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      run_q     <= run_d;
      act_q     <= act_d;
      clr_q     <= clr_d;
      past_ok_q <= 1'b1;
    end
  end

  assign dreq_hold  = run_q;
  assign out_active = act_q;
  assign xfer_clr   = clr_q;

  // R8
  clr_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q && xfer_clr |-> dreq_hold && !$past(dreq_hold));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && (setup_err || !play_en) |=> !dreq_hold && !out_active && !xfer_clr);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q && !$past(strobe) |-> $stable(dreq_hold) && !xfer_clr);
endmodule

// File: rtl/pfmt_dreq_ctrl.sv
module pfmt_dreq_ctrl
  import pfmt_pkg::*;
#(
  parameter int ENC_W = 3,
  localparam int FMT_W = RATE_W + ENC_W + 2,
  localparam int MASK_N = 1 << (RATE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FMT_W-1:0]  fmt_byte,
  input  logic              ext_mode,
  input  logic              play_en,
  input  logic              reconfig,
  input  logic [MASK_N-1:0] rate_ok_mask,
  output logic              xtal_sel,
  output logic [RATE_W-1:0] rate_idx,
  output logic              stereo,
  output logic              wide16,
  output logic              big_endian,
  output logic [1:0]        frame_shift,
  output logic [1:0]        lut_sel,
  output logic              cfg_err,
  output logic              dreq_hold,
  output logic              out_active,
  output logic              xfer_clr
);
  pcfg_t dec_cfg;
  pcfg_t cfg_q, cfg_d;
  logic  enc_bad, rate_ok, setup_err;
  logic  err_q, err_d;
  logic  past_ok_q;

  pfmt_decode #(.ENC_W(ENC_W)) u_dec (
    .fmt      (fmt_byte),
    .ext_mode (ext_mode),
    .cfg      (dec_cfg),
    .enc_bad  (enc_bad)
  );

  pfmt_rate_chk #(.RATE_W(RATE_W)) u_rate (
    .xtal    (dec_cfg.xtal),
    .rate    (dec_cfg.rate),
    .mask    (rate_ok_mask),
    .rate_ok (rate_ok)
  );

  assign setup_err = enc_bad || !rate_ok;

  always_comb begin
    cfg_d = cfg_q;
    err_d = err_q;
    if (reconfig) begin
      err_d = setup_err;
      if (!setup_err) cfg_d = dec_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      err_q     <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      cfg_q     <= cfg_d;
      err_q     <= err_d;
      past_ok_q <= 1'b1;
    end
  end

  pfmt_dreq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (reconfig),
    .play_en    (play_en),
    .setup_err  (setup_err),
    .dreq_hold  (dreq_hold),
    .out_active (out_active),
    .xfer_clr   (xfer_clr)
  );

  assign xtal_sel    = cfg_q.xtal;
  assign rate_idx    = cfg_q.rate;
  assign stereo      = cfg_q.stereo;
  assign wide16      = cfg_q.w16;
  assign big_endian  = cfg_q.big_end;
  assign frame_shift = cfg_q.shift;
  assign lut_sel     = cfg_q.lut;
  assign cfg_err     = err_q;

  // R5
  err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q && $past(reconfig) && cfg_err |-> $stable(cfg_q));

  // R10
  no_strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q && !$past(reconfig) |-> $stable(cfg_q) && $stable(cfg_err));

  // R6
  shift_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_shift == 2'd2 |-> stereo && wide16 && lut_sel == 2'd0);

  // R4
  lut_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lut_sel != 2'd0 |-> wide16 && !big_endian && lut_sel != 2'd3);
endmodule

// File: tb/sim_pfmt_dreq_ctrl.sv
`timescale 1ns/1ps
module sim_pfmt_dreq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  fmt_byte;
  logic        ext_mode, play_en, reconfig;
  logic [15:0] rate_ok_mask;
  logic        xtal_sel, stereo, wide16, big_endian, cfg_err, dreq_hold, out_active, xfer_clr;
  logic [2:0]  rate_idx;
  logic [1:0]  frame_shift, lut_sel;

  int n_chk = 0;
  int n_fail = 0;

  logic       e_xtal, e_st, e_w16, e_be, e_err, e_run, e_clr;
  logic [2:0] e_rate;
  logic [1:0] e_shift, e_lut;

  always #2 clk = ~clk;

  pfmt_dreq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fmt_byte(fmt_byte), .ext_mode(ext_mode),
    .play_en(play_en), .reconfig(reconfig), .rate_ok_mask(rate_ok_mask),
    .xtal_sel(xtal_sel), .rate_idx(rate_idx), .stereo(stereo), .wide16(wide16),
    .big_endian(big_endian), .frame_shift(frame_shift), .lut_sel(lut_sel),
    .cfg_err(cfg_err), .dreq_hold(dreq_hold), .out_active(out_active),
    .xfer_clr(xfer_clr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " R1 xtal"}, xtal_sel, e_xtal);
    chk({tag, " R1 rate"}, rate_idx, e_rate);
    chk({tag, " R2 stereo"}, stereo, e_st);
    chk({tag, " R4 wide16"}, wide16, e_w16);
    chk({tag, " R4 big_endian"}, big_endian, e_be);
    chk({tag, " R4 lut"}, lut_sel, e_lut);
    chk({tag, " R6 shift"}, frame_shift, e_shift);
    chk({tag, " R5/R7 err"}, cfg_err, e_err);
    chk({tag, " R8/R9 dreq"}, dreq_hold, e_run);
    chk({tag, " R8/R9 active"}, out_active, e_run);
    chk({tag, " R8 xfer_clr"}, xfer_clr, e_clr);
  endtask

  // Expected configuration computed from the requirement text
  task automatic model(input logic [7:0] f, input logic ext, input logic en, input logic [15:0] m);
    logic [2:0] code;
    logic bad;
    code = ext ? f[7:5] : {1'b0, f[6:5]};
    bad = (code == 3'd4) || (code == 3'd5) || (code == 3'd7) || !m[{f[0], f[3:1]}];
    e_clr = 1'b0;
    if (bad) begin
      e_err = 1'b1;
      e_run = 1'b0;
    end else begin
      e_err  = 1'b0;
      e_xtal = f[0];
      e_rate = f[3:1];
      e_st   = f[4];
      e_w16  = (code != 3'd0);
      e_be   = (code == 3'd6);
      e_lut  = (code == 3'd1) ? 2'd1 : (code == 3'd3) ? 2'd2 : 2'd0;
      if (e_w16 && e_lut == 2'd0) e_shift = e_st ? 2'd2 : 2'd1;
      else                        e_shift = e_st ? 2'd1 : 2'd0;
      if (en) begin
        e_clr = !e_run;
        e_run = 1'b1;
      end else begin
        e_run = 1'b0;
      end
    end
  endtask

  task automatic strobe(input logic [7:0] f, input logic ext, input logic en, input string tag);
    @(negedge clk);
    fmt_byte = f; ext_mode = ext; play_en = en; reconfig = 1'b1;
    model(f, ext, en, rate_ok_mask);
    @(negedge clk);
    reconfig = 1'b0;
    chk_all(tag);
    @(negedge clk);
    e_clr = 1'b0;
    chk_all({tag, " R10 after"});
  endtask

  task automatic t_reset;
    chk("R11 reset fields", {xtal_sel, rate_idx, stereo, wide16, big_endian, frame_shift, lut_sel}, 0);
    chk("R11 reset ctrl", {cfg_err, dreq_hold, out_active, xfer_clr}, 0);
  endtask

  task automatic t_fields;
    strobe(8'b000_1_101_1, 1'b1, 1'b0, "fields x1 r5 st u8");
    strobe(8'b010_0_010_0, 1'b1, 1'b0, "fields x0 r2 mono lin16");
  endtask

  task automatic t_encodings;
    int codes[5] = '{0, 1, 2, 3, 6};
    for (int i = 0; i < 5; i++) begin
      for (int s = 0; s < 2; s++) begin
        strobe({codes[i][2:0], s[0], 3'd3, 1'b0}, 1'b1, 1'b0, "R4/R6 encoding");
      end
    end
  endtask

  task automatic t_normal_mask;
    strobe(8'b110_1_000_0, 1'b0, 1'b0, "R3 normal 110->2");
    chk("R3 no big endian", big_endian, 0);
    strobe(8'b101_0_000_0, 1'b0, 1'b0, "R3 normal 101->1");
    chk("R3 mulaw", lut_sel, 1);
    strobe(8'b111_0_000_0, 1'b0, 1'b0, "R3 normal 111->3");
    chk("R3 alaw no err", cfg_err, 0);
  endtask

  task automatic t_dreq;
    strobe(8'b011_1_110_1, 1'b1, 1'b1, "R8 start");
    strobe(8'b001_1_110_1, 1'b1, 1'b1, "R8 rerun no clr");
    strobe(8'b001_1_110_1, 1'b1, 1'b0, "R9 disable");
    chk("R9 dreq low", dreq_hold, 0);
  endtask

  task automatic t_errors;
    int bad[3] = '{4, 5, 7};
    for (int i = 0; i < 3; i++) begin
      strobe(8'b011_1_011_1, 1'b1, 1'b1, "R8 restart");
      strobe({bad[i][2:0], 5'b0_000_0}, 1'b1, 1'b1, "R5 reserved");
      chk("R5 err set", cfg_err, 1);
      chk("R5 fields kept", rate_idx, 3);
      chk("R9 err release", dreq_hold, 0);
    end
    strobe(8'b010_0_001_0, 1'b1, 1'b0, "R7 good clears err");
    chk("R7 err cleared", cfg_err, 0);
  endtask

  task automatic t_rate_mask;
    rate_ok_mask = 16'hFFFF & ~(16'h1 << 12);
    strobe(8'b000_1_011_0, 1'b1, 1'b1, "R7 ok idx 3");
    strobe(8'b000_0_100_1, 1'b1, 1'b1, "R7 bad idx 12");
    chk("R7 err", cfg_err, 1);
    chk("R7 kept rate", rate_idx, 3);
    strobe(8'b000_0_100_0, 1'b1, 1'b1, "R7 ok idx 4");
    rate_ok_mask = 16'hFFFF;
  endtask

  task automatic t_no_strobe;
    strobe(8'b110_1_111_1, 1'b1, 1'b1, "R10 setup");
    @(negedge clk);
    fmt_byte = 8'h00; ext_mode = 1'b0; play_en = 1'b0; rate_ok_mask = 16'h0;
    for (int k = 0; k < 4; k++) @(negedge clk);
    e_clr = 1'b0;
    chk_all("R10 inputs moved without strobe");
    rate_ok_mask = 16'hFFFF;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fmt_byte = '0; ext_mode = 1'b0; play_en = 1'b0;
    reconfig = 1'b0; rate_ok_mask = 16'hFFFF;
    e_xtal = 0; e_rate = 0; e_st = 0; e_w16 = 0; e_be = 0;
    e_shift = 0; e_lut = 0; e_err = 0; e_run = 0; e_clr = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_encodings();
    t_normal_mask();
    t_dreq();
    t_errors();
    t_rate_mask();
    t_no_strobe();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule